// File: doc/BRIEF.md
# Strip-Partitioned Systolic Matrix-Vector Multiply-Add Array

This block computes z = A·x + y on a fixed chain of LANES multiply-add cells, for a matrix of ROWS rows and COLS columns, where COLS may be larger than the chain. The columns are cut into strips of LANES columns. There are STRIPS = ceil(COLS/LANES) of them. Each cell keeps one element of x for the strip in progress. Row sums ripple from cell to cell, one cell per cycle. A delay line carries each unfinished row sum from the tail cell back to the head cell. It arrives there in the same cycle as the same row of the next strip. In the last strip, the sums leave on the output instead.

The host pulses `start`, then streams one row of one strip per cycle, strip by strip, for ROWS·STRIPS cycles. The block skews the lanes internally. Lane j is held back j cycles, so each cell sees its matrix element exactly when the partial sum for that row reaches it. The result rows come out on consecutive cycles. A one-cycle `done` pulse follows the last of them. The design requires ROWS ≥ LANES. Arithmetic is signed two's complement, and the output is wide enough for any full row sum.

Top module: `strip_gaxpy_array`

## Requirements
- R1: During and after reset, before any run, `z_valid` and `done` are low and `z_out` is zero.
- R2: For each row i, the value emitted is y_i + Σ over columns c < COLS of a(i,c)·x_c. It is exact in signed arithmetic over the full input range, including all-most-negative operands.
- R3: Cycle 1 is the cycle after the edge that samples `start`. In cycle c, for c = 1..ROWS·STRIPS, the host drives row i = (c−1) mod ROWS of strip k = (c−1) div ROWS, both counted from 0. Lane j (0-based) of `a_row`, bits [j·DW +: DW], carries a(i, k·LANES+j).
- R4: Row i (0-based) of the result is on `z_out` with `z_valid` high in cycle (STRIPS−1)·ROWS + LANES + i + 1. The rows come in order on ROWS consecutive cycles, and `z_valid` is low at every other time.
- R5: `done` is high for exactly one cycle, cycle STRIPS·ROWS + LANES + 1, which is the cycle after the last result.
- R6: A `start` pulse while a run is in progress, whether inputs are still being streamed or the chain is draining, has no effect. No extra results appear, and the timing of `done` does not change.
- R7: In the last strip, lanes whose column index k·LANES+j is ≥ COLS are treated as zero padding. Their `a_row` and `x_vec` values do not affect the result.
- R8: `x_vec` lane j is taken only in the first-row cycle of each strip (i = 0), and is held for the rest of that strip. `y_in` is taken only in the cycles of strip 0, and carries y_i in cycle i+1.
- R9: A `start` in the cycle where `done` is high begins a new run with the same schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a run when the block is idle |
| a_row | input | LANES·DW | One strip row of matrix elements, lane j in bits [j·DW +: DW], signed |
| x_vec | input | LANES·DW | x elements of the current strip, sampled on its first row, signed |
| y_in | input | DW | Addend y_i, sampled during strip 0, signed |
| z_out | output | AW | Result row sum, signed, AW = 2·DW + clog2(COLS+1) + 1 |
| z_valid | output | 1 | z_out holds a result row |
| done | output | 1 | One-cycle pulse after the last result row |

## Verification
Every result is due a fixed number of cycles after the edge that samples `start`. Row i is due (STRIPS−1)·ROWS + LANES + i + 1 cycles later, and `done` is due STRIPS·ROWS + LANES + 1 cycles later. The scoreboard stamps each expected row and each expected `done` with its due cycle when the run starts. The monitor samples on the falling edge and compares both the value and the cycle of arrival, so a result that is early, late or unexpected fails. The stimulus puts non-zero junk on every lane and cycle that must be ignored: padded lanes, `x_vec` outside first rows, `y_in` after strip 0, and `start` during feed and drain. Any leak therefore shows up in a value or an arrival cycle.

// File: rtl/gx_pkg.sv
package gx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/gx_skew.sv
// Delays lane j of the incoming strip row by j cycles so that each cell
// sees its matrix element, x element and load flag in step with the
// partial sum that reaches it.
module gx_skew #(
  parameter int LANES = 4,
  parameter int DW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES*DW-1:0] a_in,
  input  logic [LANES*DW-1:0] x_in,
  input  logic               ld_in,
  output logic [LANES*DW-1:0] a_out,
  output logic [LANES*DW-1:0] x_out,
  output logic [LANES-1:0]   ld_out
);

  localparam int SW = 2 * DW + 1;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j == 0) begin : g_direct
      assign a_out[DW-1:0] = a_in[DW-1:0];
      assign x_out[DW-1:0] = x_in[DW-1:0];
      assign ld_out[0]     = ld_in;
    end else begin : g_delay
      logic [j-1:0][SW-1:0] pipe_q;
      logic [j-1:0][SW-1:0] pipe_d;

      always_comb begin
        pipe_d[0] = {ld_in, x_in[j*DW +: DW], a_in[j*DW +: DW]};
        for (int s = 1; s < j; s++) begin
          pipe_d[s] = pipe_q[s-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= '0;
        end else begin
          pipe_q <= pipe_d;
        end
      end

      assign {ld_out[j], x_out[j*DW +: DW], a_out[j*DW +: DW]} = pipe_q[j-1];
    end
  end

endmodule

// File: rtl/gx_cell.sv
// One multiply-add cell: registers sum_in + a*x and keeps its x element
// for the strip in progress.
module gx_cell #(
  parameter int DW = 8,
  parameter int AW = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        a_in,
  input  logic [DW-1:0]        x_in,
  input  logic                 x_ld,
  input  logic signed [AW-1:0] sum_in,
  input  logic                 tag_in,
  output logic signed [AW-1:0] sum_q,
  output logic                 tag_q
);

  logic signed [DW-1:0]   x_q;
  logic signed [DW-1:0]   x_use;
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   sum_d;

  always_comb begin
    x_use = x_ld ? signed'(x_in) : x_q;
    prod  = signed'(a_in) * x_use;
    sum_d = sum_in + AW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      sum_q <= '0;
      tag_q <= 1'b0;
    end else begin
      if (x_ld) begin
        x_q <= x_use;
      end
      sum_q <= sum_d;
      tag_q <= tag_in;
    end
  end

endmodule

// File: rtl/gx_recirc.sv
// Fixed delay line returning partial row sums from the tail cell to the
// head cell; DLY = 0 degenerates to a wire.
module gx_recirc #(
  parameter int AW  = 21,
  parameter int DLY = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [AW-1:0] din,
  output logic signed [AW-1:0] dout
);

  if (DLY == 0) begin : g_wire
    assign dout = din;
  end else begin : g_line
    logic [DLY-1:0][AW-1:0] line_q;
    logic [DLY-1:0][AW-1:0] line_d;

    always_comb begin
      line_d[0] = din;
      for (int s = 1; s < DLY; s++) begin
        line_d[s] = line_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q <= '0;
      end else begin
        line_q <= line_d;
      end
    end

    assign dout = signed'(line_q[DLY-1]);
  end

endmodule

// File: rtl/gx_sequencer.sv
// Run control: walks rows and strips during feed, then waits for the last
// tagged result to leave the chain and raises done.
module gx_sequencer
  import gx_pkg::*;
#(
  parameter int ROWS   = 6,
  parameter int STRIPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tail_tag,
  input  logic lead_tag,
  output logic feed,
  output logic first_row,
  output logic first_strip,
  output logic last_strip,
  output logic busy,
  output logic done
);

  localparam int RW = $clog2(ROWS + 1);
  localparam int SW = $clog2(STRIPS + 1);
  localparam logic [RW-1:0] ROW_LAST   = RW'(ROWS - 1);
  localparam logic [SW-1:0] STRIP_LAST = SW'(STRIPS - 1);

  run_state_t      state_q, state_d;
  logic [RW-1:0]   row_q, row_d;
  logic [SW-1:0]   strip_q, strip_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    strip_d = strip_q;
    done_d  = (state_q == ST_DRAIN) && tail_tag && !lead_tag;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FEED;
          row_d   = '0;
          strip_d = '0;
        end
      end
      ST_FEED: begin
        if (row_q == ROW_LAST) begin
          row_d = '0;
          if (strip_q == STRIP_LAST) begin
            state_d = ST_DRAIN;
          end else begin
            strip_d = strip_q + 1'b1;
          end
        end else begin
          row_d = row_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (done_d) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      strip_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      strip_q <= strip_d;
      done_q  <= done_d;
    end
  end

  assign feed        = (state_q == ST_FEED);
  assign busy        = (state_q != ST_IDLE);
  assign first_row   = feed && (row_q == '0);
  assign first_strip = feed && (strip_q == '0);
  assign last_strip  = feed && (strip_q == STRIP_LAST);
  assign done        = done_q;

endmodule

// File: rtl/strip_gaxpy_array.sv
module strip_gaxpy_array
  import gx_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int ROWS  = 6,
  parameter int COLS  = 10,
  // derived output width; keep at its default
  parameter int AW    = 2 * DW + $clog2(COLS + 1) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LANES*DW-1:0] a_row,
  input  logic [LANES*DW-1:0] x_vec,
  input  logic [DW-1:0]       y_in,
  output logic [AW-1:0]       z_out,
  output logic                z_valid,
  output logic                done
);

  localparam int STRIPS = ceil_div(COLS, LANES);
  localparam int TAIL   = COLS - (STRIPS - 1) * LANES;
  localparam int DLY    = ROWS - LANES;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  logic feed, first_row, first_strip, last_strip, run_busy;
  logic tail_tag, lead_tag, head_tag;

  logic [LANES*DW-1:0] x_msk, a_sk, x_sk;
  logic [LANES-1:0]    ld_sk;

  logic signed [AW-1:0] cell_sum [LANES];
  logic                 cell_tag [LANES];
  logic signed [AW-1:0] recirc_out, head_sum;
  logic signed [DW-1:0] y_s;

  // zero padding for the lanes beyond the last real column
  for (genvar j = 0; j < LANES; j++) begin : g_pad
    if (j >= TAIL) begin : g_masked
      assign x_msk[j*DW +: DW] = last_strip ? '0 : x_vec[j*DW +: DW];
    end else begin : g_open
      assign x_msk[j*DW +: DW] = x_vec[j*DW +: DW];
    end
  end

  gx_sequencer #(
    .ROWS   (ROWS),
    .STRIPS (STRIPS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (start),
    .tail_tag    (tail_tag),
    .lead_tag    (lead_tag),
    .feed        (feed),
    .first_row   (first_row),
    .first_strip (first_strip),
    .last_strip  (last_strip),
    .busy        (run_busy),
    .done        (done)
  );

  gx_skew #(
    .LANES (LANES),
    .DW    (DW)
  ) u_skew (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .a_in   (a_row),
    .x_in   (x_msk),
    .ld_in  (first_row),
    .a_out  (a_sk),
    .x_out  (x_sk),
    .ld_out (ld_sk)
  );

  assign y_s      = signed'(y_in);
  assign head_sum = first_strip ? AW'(y_s) : recirc_out;
  assign head_tag = last_strip;

  for (genvar j = 0; j < LANES; j++) begin : g_chain
    if (j == 0) begin : g_head
      gx_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .a_in   (a_sk[DW-1:0]),
        .x_in   (x_sk[DW-1:0]),
        .x_ld   (ld_sk[0]),
        .sum_in (head_sum),
        .tag_in (head_tag),
        .sum_q  (cell_sum[0]),
        .tag_q  (cell_tag[0])
      );
    end else begin : g_body
      gx_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .a_in   (a_sk[j*DW +: DW]),
        .x_in   (x_sk[j*DW +: DW]),
        .x_ld   (ld_sk[j]),
        .sum_in (cell_sum[j-1]),
        .tag_in (cell_tag[j-1]),
        .sum_q  (cell_sum[j]),
        .tag_q  (cell_tag[j])
      );
    end
  end

  if (LANES > 1) begin : g_lead_cell
    assign lead_tag = cell_tag[LANES-2];
  end else begin : g_lead_head
    assign lead_tag = head_tag;
  end

  assign tail_tag = cell_tag[LANES-1];

  gx_recirc #(
    .AW  (AW),
    .DLY (DLY)
  ) u_recirc (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (cell_sum[LANES-1]),
    .dout  (recirc_out)
  );

  assign z_out   = cell_sum[LANES-1];
  assign z_valid = tail_tag;

endmodule

// File: rtl/gx_checker.sv
module gx_checker #(
  parameter int ROWS   = 6,
  parameter int STRIPS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic feed,
  input logic z_valid,
  input logic done
);

  logic [15:0] zcnt_q, fcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      zcnt_q <= done ? 16'd0 : zcnt_q + 16'(z_valid);
      fcnt_q <= feed ? fcnt_q + 16'd1 : 16'd0;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(z_valid) |-> done);

  // R4
  row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (zcnt_q == 16'(ROWS)));

  // R4
  result_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z_valid |-> busy);

  // R6
  feed_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(feed) |-> (fcnt_q == 16'(ROWS * STRIPS)));

endmodule

bind strip_gaxpy_array gx_checker #(
  .ROWS   (ROWS),
  .STRIPS (STRIPS)
) u_gx_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .busy    (run_busy),
  .feed    (feed),
  .z_valid (z_valid),
  .done    (done)
);

// File: tb/tb_strip_gaxpy_array.sv
`timescale 1ns/1ps
module tb_strip_gaxpy_array;

  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int M    = 6;
  localparam int P    = 10;
  localparam int RHO  = (P + N - 1) / N;
  localparam int AW   = 2 * DW + $clog2(P + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*DW-1:0] a_row = '0;
  logic [N*DW-1:0] x_vec = '0;
  logic [DW-1:0]   y_in  = '0;
  logic [AW-1:0]   z_out;
  logic            z_valid;
  logic            done;

  always #2 clk = ~clk;

  strip_gaxpy_array #(.LANES(N), .DW(DW), .ROWS(M), .COLS(P)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_row(a_row),
    .x_vec(x_vec), .y_in(y_in), .z_out(z_out), .z_valid(z_valid), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  int z_seen = 0, z_expected = 0, done_seen = 0, done_expected = 0;

  int A [M][P];
  int X [P];
  int Y [M];

  typedef struct {
    longint val;
    int     due;
    string  tag;
  } zexp_t;

  zexp_t zq [$];
  int    dq [$];
  zexp_t e;
  int    d;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void set_job(input int kind);
    for (int i = 0; i < M; i++) begin
      for (int c = 0; c < P; c++) begin
        case (kind)
          0: A[i][c] = ((i * 3 + c * 5) % 17) - 8;
          1: A[i][c] = -128;
          2: A[i][c] = -128;
          3: A[i][c] = ((i + 2 * c) % 9) - 4;
          default: A[i][c] = 0;
        endcase
      end
    end
    for (int c = 0; c < P; c++) begin
      case (kind)
        0: X[c] = ((c * 7) % 11) - 5;
        1: X[c] = -128;
        2: X[c] = 127;
        3: X[c] = (c % 5) * 20 - 40;
        default: X[c] = ((c * 13) % 23) - 11;
      endcase
    end
    for (int i = 0; i < M; i++) begin
      case (kind)
        0: Y[i] = i * 9 - 20;
        1: Y[i] = 127;
        2: Y[i] = -128;
        3: Y[i] = 100 - i * 37;
        default: Y[i] = i * 41 - 100;
      endcase
    end
  endfunction

  // R3: row i of strip k in its cycle; R7/R8: junk on every ignored lane
  task automatic drive_row(input int k, input int i);
    for (int j = 0; j < N; j++) begin
      int col;
      col = k * N + j;
      a_row[j*DW +: DW] = (col < P) ? DW'(A[i][col]) : DW'(-99);
      if (i == 0) x_vec[j*DW +: DW] = (col < P) ? DW'(X[col]) : DW'(77);
      else        x_vec[j*DW +: DW] = DW'(55);
    end
    y_in = (k == 0) ? DW'(Y[i]) : DW'(-33);
  endtask

  // called at a falling edge; start is sampled at the next rising edge
  task automatic run_job(input int poke, input string tag);
    int s0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s0 = cyc;
    for (int i = 0; i < M; i++) begin
      zexp_t n;
      longint s;
      s = Y[i];
      for (int c = 0; c < P; c++) s += longint'(A[i][c]) * longint'(X[c]);
      n.val = s;
      n.due = s0 + (RHO - 1) * M + N + i;
      n.tag = tag;
      zq.push_back(n);
      z_expected++;
    end
    dq.push_back(s0 + RHO * M + N);
    done_expected++;
    for (int c = 0; c < RHO * M; c++) begin
      drive_row(c / M, c % M);
      start = ((c + 1) == poke);
      @(negedge clk);
    end
    a_row = '0;
    x_vec = '0;
    y_in  = '0;
    start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (z_valid) begin
        z_seen++;
        if (zq.size() == 0) begin
          check(1'b0, "R4", "unexpected result", cyc, -1);
        end else begin
          e = zq.pop_front();
          check(longint'($signed(z_out)) == e.val, e.tag, "result value",
                longint'($signed(z_out)), e.val);
          check(cyc == e.due, "R4", "result cycle", cyc, e.due);
        end
      end
      if (done) begin
        done_seen++;
        if (dq.size() == 0) begin
          check(1'b0, "R5", "unexpected done", cyc, -1);
        end else begin
          d = dq.pop_front();
          check(cyc == d, "R5", "done cycle", cyc, d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(z_valid == 1'b0, "R1", "z_valid in reset", z_valid, 0);
    check(done == 1'b0, "R1", "done in reset", done, 0);
    check(z_out == '0, "R1", "z_out in reset", z_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(z_valid == 1'b0 && done == 1'b0, "R1", "outputs idle after reset",
          {z_valid, done}, 0);
    check(z_out == '0, "R1", "z_out after reset", z_out, 0);

    set_job(0);
    run_job(0, "R2/R3/R7/R8");
    repeat (N + 4) @(negedge clk);

    set_job(1);
    run_job(0, "R2 max positive");
    repeat (N + 4) @(negedge clk);

    set_job(2);
    run_job(0, "R2 max negative");
    repeat (N + 4) @(negedge clk);

    // R6: start raised mid feed and again during drain
    set_job(3);
    run_job(9, "R6");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 4) @(negedge clk);

    // R8: all-zero matrix, the result is y alone
    set_job(4);
    run_job(0, "R8");
    // R9: next start lands in the done cycle
    repeat (N) @(negedge clk);
    set_job(0);
    run_job(0, "R9");
    repeat (N + 8) @(negedge clk);

    check(zq.size() == 0, "R4", "results outstanding", zq.size(), 0);
    check(dq.size() == 0, "R5", "done outstanding", dq.size(), 0);
    check(z_seen == z_expected, "R6", "result count", z_seen, z_expected);
    check(done_seen == done_expected, "R6", "done count", done_seen, done_expected);
    check(z_valid == 1'b0 && done == 1'b0, "R4", "idle after runs",
          {z_valid, done}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule